// File: doc/BRIEF.md
# Dual Timer/Counter with Four Operating Modes

This block holds two up-counting timer/counters. Each one is a pair of 8-bit registers, a low byte and a high byte. A timer counts either a machine-cycle tick or falling edges on its own event pin. The tick is produced every `TICK_DIV` clocks, 12 by default. Counting is qualified by a run bit, and optionally by a gate pin. A two-bit mode field sets how the two bytes relate to each other:

- a 13-bit count with a 5-bit low-byte prescaler;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split mode in which timer 0 becomes two independent 8-bit counters.

Each timer raises a sticky overflow flag. Software loads the count bytes, the mode byte and the control byte through a simple register port with a write strobe and a combinational read mux. Software or an interrupt controller clears a flag, either with a write-one to the control byte or with a one-cycle acknowledge pulse.

The register map is as follows:

| Address | Register |
|---|---|
| 0 | Timer 0 low byte |
| 1 | Timer 0 high byte |
| 2 | Timer 1 low byte |
| 3 | Timer 1 high byte |
| 4 | Mode byte |
| 5 | Control byte |

The mode byte has four bits per timer, with timer 0 in bits 3:0 and timer 1 in bits 7:4. Within each nibble, bits [1:0] hold the mode, bit 2 is the event-source select and bit 3 is the gate enable.

The control byte uses four bits:
- bit 0 is run 0 and bit 2 is run 1;
- bit 1 is flag 0 and bit 3 is flag 1.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every count byte, the mode byte and the control byte read 00h, and both flag outputs are 0.
- R2: Writes to addresses 0 to 4 are read back unchanged at the same address. A write to a count byte takes priority over counting in the same cycle.
- R3: With the source select at 0, a counting timer adds one per tick, and a tick occurs once every 12 clocks. With the source select at 1, the event pin is sampled once per tick, and a high sample followed by a low sample adds exactly one.
- R4: A timer counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Otherwise its bytes hold.
- R5: Mode 00: low byte bits [4:0] act as a prescaler below the 8-bit high byte, and low byte bits [7:5] are left unchanged. The flag sets when the high byte wraps from FFh to 00h.
- R6: Mode 01: the low and high bytes form one 16-bit counter. The flag sets when the count wraps from FFFFh to 0000h.
- R7: Mode 10: the low byte counts alone. On the count after FFh it loads the high byte value and sets the flag. The high byte is unchanged.
- R8: Mode 11: timer 1 holds its count. Timer 0's low byte counts under run 0, gate 0 and source 0, and sets flag 0. Timer 0's high byte counts the tick under run 1 alone, ignoring gate 0 and source 0, and sets flag 1 on FFh to 00h. While timer 0 is split, timer 1 cannot set flag 1.
- R9: A flag stays 1 until it is cleared. A write to address 5 with its flag bit set clears it, and writing a 0 there leaves it unchanged. An acknowledge pulse on its ack_i bit also clears it. An overflow in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| evt_i | input | 2 | External event pins, bit k for timer k |
| gate_pin_i | input | 2 | Gate qualifier pins, bit k for timer k |
| ack_i | input | 2 | Flag acknowledge pulses, bit k clears flag k |
| flag_o | output | 2 | Overflow flags |

## Verification
On every cycle, the assertions check the following:
- timer 0's low byte stays still while run 0 is clear, unless it is being written;
- timer 1 holds while it is in split mode;
- each flag stays set unless it sees a clear, and never drops without an acknowledge or a write-one.

Only the bench scenarios can show:
- the exact count arithmetic of each mode: prescaler carry, 16-bit wrap and reload value;
- the tick rate and event-pin edge counting;
- the split of the run and flag bits between timer 0's two halves;
- the results of gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_TMR  = 2;

  typedef enum logic [1:0] {
    M_13B    = 2'b00,
    M_16B    = 2'b01,
    M_RELOAD = 2'b10,
    M_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      csel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic pin_i,
  output logic fall_o
);
  logic smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          smp_q <= 1'b0;
    else if (sample_en_i) smp_q <= pin_i;
  end

  // previous sample high, this sample low
  assign fall_o = sample_en_i & smp_q & ~pin_i;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned PW       = 5,
  parameter bit          SPLIT_OK = 1'b1
) (
  input  tmr_mode_e      mode_i,
  input  logic           inc_i,
  input  logic           inc_hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   hi_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output logic           ovf_o,
  output logic           ovf_hi_o
);
  always_comb begin
    lo_o     = lo_i;
    hi_o     = hi_i;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      M_13B: if (inc_i) begin
        lo_o[PW-1:0] = lo_i[PW-1:0] + 1'b1;
        if (&lo_i[PW-1:0]) begin
          hi_o  = hi_i + 1'b1;
          ovf_o = &hi_i;
        end
      end
      M_16B: if (inc_i) begin
        lo_o = lo_i + 1'b1;
        if (&lo_i) begin
          hi_o  = hi_i + 1'b1;
          ovf_o = &hi_i;
        end
      end
      M_RELOAD: if (inc_i) begin
        if (&lo_i) begin
          lo_o  = hi_i;
          ovf_o = 1'b1;
        end else begin
          lo_o  = lo_i + 1'b1;
        end
      end
      M_SPLIT: if (SPLIT_OK) begin
        if (inc_i) begin
          lo_o  = lo_i + 1'b1;
          ovf_o = &lo_i;
        end
        if (inc_hi_i) begin
          hi_o     = hi_i + 1'b1;
          ovf_hi_o = &hi_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned TICK_DIV = 12,
  parameter int unsigned PRE_W    = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  output logic [BYTE_W-1:0]     rdata_o,
  input  logic [N_TMR-1:0]      evt_i,
  input  logic [N_TMR-1:0]      gate_pin_i,
  input  logic [N_TMR-1:0]      ack_i,
  output logic [N_TMR-1:0]      flag_o
);
  logic                         tick;
  logic [N_TMR-1:0][BYTE_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
  tmr_cfg_t [N_TMR-1:0]         cfg_q;
  logic [N_TMR-1:0]             run_q, flag_q;
  logic [N_TMR-1:0]             fall, inc, inc_hi, ovf, ovf_hi, set_flag;
  logic                         split0, ctrl_wr;

  tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign split0  = (cfg_q[0].mode == M_SPLIT);
  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * k + 1);
    logic              gate_ok;
    logic [BYTE_W-1:0] lo_r, hi_r;

    tmr_edge_det u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sample_en_i(tick),
      .pin_i      (evt_i[k]),
      .fall_o     (fall[k])
    );

    assign gate_ok = run_q[k] & (~cfg_q[k].gate | gate_pin_i[k]);
    assign inc[k]  = gate_ok & (cfg_q[k].csel ? fall[k] : tick);

    if (k == 0) begin : g_hi_src
      assign inc_hi[k] = run_q[1] & tick;   // split high half: tick only
    end else begin : g_hi_none
      assign inc_hi[k] = 1'b0;
    end

    tmr_unit #(.W(BYTE_W), .PW(PRE_W), .SPLIT_OK(k == 0)) u_unit (
      .mode_i  (cfg_q[k].mode),
      .inc_i   (inc[k]),
      .inc_hi_i(inc_hi[k]),
      .lo_i    (lo_q[k]),
      .hi_i    (hi_q[k]),
      .lo_o    (lo_nxt[k]),
      .hi_o    (hi_nxt[k]),
      .ovf_o   (ovf[k]),
      .ovf_hi_o(ovf_hi[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_r <= '0;
        hi_r <= '0;
      end else begin
        lo_r <= (wr_en_i && addr_i == A_LO) ? wdata_i : lo_nxt[k];
        hi_r <= (wr_en_i && addr_i == A_HI) ? wdata_i : hi_nxt[k];
      end
    end
    assign lo_q[k] = lo_r;
    assign hi_q[k] = hi_r;
  end

  assign set_flag[0] = ovf[0];
  assign set_flag[1] = split0 ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en_i && addr_i == A_MODE) cfg_q <= wdata_i;
      if (ctrl_wr) run_q <= {wdata_i[2], wdata_i[0]};
      for (int k = 0; k < N_TMR; k++) begin
        if (set_flag[k])
          flag_q[k] <= 1'b1;
        else if (ack_i[k] || (ctrl_wr && wdata_i[2*k+1]))
          flag_q[k] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      3'd0:    rdata_o = lo_q[0];
      3'd1:    rdata_o = hi_q[0];
      3'd2:    rdata_o = lo_q[1];
      3'd3:    rdata_o = hi_q[1];
      A_MODE:  rdata_o = cfg_q;
      A_CTRL:  rdata_o = {4'b0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
      default: rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [BYTE_W-1:0]            wdata_i,
  input logic [N_TMR-1:0]             ack_i,
  input logic [N_TMR-1:0]             flag_o,
  input logic [N_TMR-1:0]             run_q,
  input logic [1:0]                   t1_mode,
  input logic [N_TMR-1:0][BYTE_W-1:0] lo_q,
  input logic [N_TMR-1:0][BYTE_W-1:0] hi_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);

  // R4
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && !(wr_en_i && addr_i == 3'd0)) |=> $stable(lo_q[0]));

  // R8
  split_t1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_mode == 2'b11 && !(wr_en_i && (addr_i == 3'd2 || addr_i == 3'd3)))
      |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

  // R9
  flag0_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && !ack_i[0] && !(ctrl_wr && wdata_i[1])) |=> flag_o[0]);

  // R9
  flag1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !ack_i[1] && !(ctrl_wr && wdata_i[3])) |=> flag_o[1]);

  // R9
  flag0_clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o[0]) |-> $past(ack_i[0] || (ctrl_wr && wdata_i[1])));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .ack_i  (ack_i),
  .flag_o (flag_o),
  .run_q  (run_q),
  .t1_mode(cfg_q[1].mode),
  .lo_q   (lo_q),
  .hi_q   (hi_q)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] evt = 2'b11;
  logic [1:0] gpin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic [1:0] flag;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmr_pair uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .gate_pin_i(gpin),
    .ack_i(ack), .flag_o(flag)
  );

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] n;
    logic [7:0] exp_lo;
    logic [7:0] exp_hi;
    logic [7:0] exp_flag;
  } vec_t;

  // timer 0 vectors: mode, preload lo/hi, ticks, expected lo/hi/flag
  localparam vec_t VEC [7] = '{
    '{8'h01, 8'h00, 8'h00, 8'd5, 8'h05, 8'h00, 8'd0},  // R6
    '{8'h01, 8'hFE, 8'h12, 8'd3, 8'h01, 8'h13, 8'd0},  // R6 carry
    '{8'h01, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 8'd1},  // R6 wrap
    '{8'h00, 8'hFE, 8'h07, 8'd3, 8'hE1, 8'h08, 8'd0},  // R5 bits 7:5 kept
    '{8'h00, 8'h1F, 8'hFF, 8'd2, 8'h01, 8'h00, 8'd1},  // R5 wrap
    '{8'h02, 8'hFD, 8'h40, 8'd4, 8'h41, 8'h40, 8'd1},  // R7 reload
    '{8'h02, 8'h10, 8'h80, 8'd2, 8'h12, 8'h80, 8'd0}   // R7
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // run for exactly n ticks of 12 clocks each, then stop (flags untouched)
  task automatic run_for(input int n, input logic [7:0] ctrl_on);
    wr(3'd5, ctrl_on);
    repeat (12 * n - 1) @(posedge clk);
    wr(3'd5, 8'h00);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset flags", {6'b0, flag}, 8'h00);

    // R2 readback
    wr(3'd2, 8'hA5); wr(3'd3, 8'h5A); wr(3'd4, 8'h00);
    rd(3'd2, d); chk("R2 t1 lo", d, 8'hA5);
    rd(3'd3, d); chk("R2 t1 hi", d, 8'h5A);
    wr(3'd4, 8'hC3);
    rd(3'd4, d); chk("R2 mode", d, 8'hC3);

    // R3 R5 R6 R7 vector table, internal tick
    foreach (VEC[i]) begin
      wr(3'd5, 8'h0A);
      wr(3'd4, VEC[i].mode);
      wr(3'd0, VEC[i].lo);
      wr(3'd1, VEC[i].hi);
      run_for(int'(VEC[i].n), 8'h01);
      rd(3'd0, d); chk($sformatf("R3/R5-R7 vec%0d lo", i), d, VEC[i].exp_lo);
      rd(3'd1, d); chk($sformatf("R5-R7 vec%0d hi", i), d, VEC[i].exp_hi);
      chk($sformatf("R5-R7 vec%0d flag", i), {7'b0, flag[0]}, VEC[i].exp_flag);
    end

    // R4 gating: gate on, pin low -> hold; pin high -> count
    wr(3'd5, 8'h0A);
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h20); wr(3'd1, 8'h00);
    gpin = 2'b00;
    run_for(3, 8'h01);
    rd(3'd0, d); chk("R4 gated hold", d, 8'h20);
    gpin = 2'b01;
    run_for(3, 8'h01);
    rd(3'd0, d); chk("R4 gate pin high counts", d, 8'h23);
    repeat (30) @(posedge clk);
    rd(3'd0, d); chk("R4 run clear holds", d, 8'h23);
    gpin = 2'b00;

    // R3 event counting on pin 0: four high->low transitions
    wr(3'd4, 8'h05);
    wr(3'd0, 8'h00);
    evt[0] = 1'b1;
    wr(3'd5, 8'h01);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) evt[0] = 1'b1;
      repeat (24) @(negedge clk);
      evt[0] = 1'b0;
      repeat (24) @(negedge clk);
    end
    evt[0] = 1'b1;
    wr(3'd5, 8'h00);
    rd(3'd0, d); chk("R3 event edges counted", d, 8'h04);

    // R8 split mode: lo gated off, hi counts on run1 only, t1 holds
    wr(3'd5, 8'h0A);
    wr(3'd4, 8'h3B);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFE);
    wr(3'd2, 8'h55); wr(3'd3, 8'h66);
    gpin = 2'b00;
    run_for(2, 8'h05);
    rd(3'd0, d); chk("R8 split lo gated", d, 8'hFE);
    rd(3'd1, d); chk("R8 split hi ignores gate", d, 8'h00);
    chk("R8 flags after hi wrap", {6'b0, flag}, 8'h02);
    gpin = 2'b01;
    run_for(3, 8'h05);
    gpin = 2'b00;
    rd(3'd0, d); chk("R8 split lo counts", d, 8'h01);
    rd(3'd1, d); chk("R8 split hi", d, 8'h03);
    rd(3'd2, d); chk("R8 t1 lo held", d, 8'h55);
    rd(3'd3, d); chk("R8 t1 hi held", d, 8'h66);
    chk("R8 both flags", {6'b0, flag}, 8'h03);

    // R9 sticky, ack clear, write-one clear
    repeat (40) @(posedge clk);
    chk("R9 flags sticky", {6'b0, flag}, 8'h03);
    wr(3'd5, 8'h00);
    chk("R9 write zero keeps flags", {6'b0, flag}, 8'h03);
    @(negedge clk) ack = 2'b10;
    @(negedge clk) ack = 2'b00;
    chk("R9 ack clears flag1 only", {6'b0, flag}, 8'h01);
    wr(3'd5, 8'h02);
    chk("R9 write one clears flag0", {6'b0, flag}, 8'h00);

    summary();
  end
endmodule